// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the time base that a two-channel pulse-width modulator is built on. A 16-bit counter advances once for every tick of a prescaler. The prescale factor is the product of two programmable dividers. The first divider is indexed: its factor is 1 for index 0 and twice the index otherwise. The second divider is a power of two. The counter counts up, counts down or counts up-down between zero and a period value, or holds still. Both output channels share the one period value. Downstream compare and action logic uses the counter value and two single-cycle strobes: one when the counter reaches zero and one when it reaches the period.

The period has an active copy and a shadow copy. A load-mode bit in the control word selects how a software period write is handled. The write either goes straight to the active copy, or it is held in the shadow and moved into the active copy when the counter next reaches zero. Software reaches the block through a single-cycle write port and a combinational read port.

A small state machine tracks the count direction. ST_IDLE is the reset and freeze state. ST_RISE is the counting-up state, and ST_FALL is the counting-down state. On each tick the up mode moves to ST_RISE and the down mode moves to ST_FALL. In up-down mode the machine goes from ST_RISE to ST_FALL when the count is at or above the period, and from ST_FALL to ST_RISE when the count is zero. ST_IDLE acts like ST_RISE in up-down mode. The freeze mode moves to ST_IDLE.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the control word reads 16'h0003 (freeze mode), the active and shadow periods read 0, and both strobes are low.
- R2: The control word is written at address 0 and read back from address 0. Its fields are: bits 1:0 are the mode (00 up, 01 down, 10 up-down, 11 freeze), bit 3 is the load mode (1 immediate, 0 shadow), bits 9:7 are the first divider index and bits 12:10 are the second divider index. All other bits read as 0.
- R3: The prescale factor is F = (first index = 0 ? 1 : 2 × first index) × 2^(second index). The count changes only on ticks, which are F clock cycles apart. A control write restarts the prescaler, so the first tick after it falls F cycles after the write edge, and the write edge itself is never a tick.
- R4: In up mode each tick adds 1 to the count. When the count is at or above the active period, the tick sets it to 0 instead.
- R5: In down mode each tick subtracts 1 from the count. A count of 0 reloads the active period.
- R6: In up-down mode the count climbs to the period and then steps down. It falls to 0 and then steps up again. From reset it starts by counting up.
- R7: In freeze mode the count holds its value, and neither strobe is raised.
- R8: The zero strobe is high for exactly one clock cycle. That is the cycle in which a tick has just made the count 0 while the mode is not freeze. The period strobe works the same way for a new count equal to the active period in use at that tick. Both strobes can be high together.
- R9: With load mode 1, a period write at address 1 sets the active period at that edge and leaves the shadow unchanged.
- R10: With load mode 0, a period write at address 1 sets only the shadow. The active period takes the shadow value at the tick that makes the count 0. A write that lands on that same edge goes to the shadow, and the active period takes the previous shadow value.
- R11: Reads return the control word at address 0, the active period at address 1, the shadow period at address 2 and the count at address 3. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| count_out | output | 16 | Current counter value |
| zero_evt | output | 1 | Counter-reached-zero strobe |
| period_evt | output | 1 | Counter-reached-period strobe |

## Verification
Two functions can fall on the same clock edge: a software period write in shadow mode and the transfer from shadow to active that happens when the counter wraps to zero. The bench waits until the counter sits one tick below the wrap. It then issues the period write so that the write lands on the wrap edge. The result passes only if the active period then holds the previous shadow value while the shadow holds the new one. The new value must also reach the active copy at the following zero.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    // Register addresses on the write/read port
    localparam int ADDR_W        = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_PRD  = 2'd1;
    localparam logic [ADDR_W-1:0] A_SHD  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd3;

    // Control word layout (positions are decoded by software)
    localparam int MODE_LSB = 0;
    localparam int MODE_W   = 2;
    localparam int IMM_BIT  = 3;
    localparam int HS_LSB   = 7;
    localparam int HS_W     = 3;
    localparam int DV_LSB   = 10;
    localparam int DV_W     = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_HOLD = 2'b11
    } ptb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } ptb_state_e;

endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler
    import ptb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [HS_W-1:0] hs_idx,
    input  logic [DV_W-1:0] dv_idx,
    output logic            tick
);

    // Widest factor: 2*(2^HS_W-1) * 2^(2^DV_W-1)
    localparam int PS_W = HS_W + 1 + (2**DV_W - 1);

    logic [HS_W:0]   hs_fac;
    logic [PS_W-1:0] factor;
    logic [PS_W-1:0] div_q;
    logic            wrap;

    // First stage: 1 for index 0, otherwise twice the index
    always_comb begin
        if (hs_idx == '0) begin
            hs_fac = (HS_W+1)'(1);
        end else begin
            hs_fac = {hs_idx, 1'b0};
        end
        factor = PS_W'(hs_fac) << dv_idx;
    end

    // >= keeps the divider safe when the factor shrinks mid-count
    assign wrap = (div_q >= (factor - 1'b1));
    assign tick = wrap && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart || wrap) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  ptb_mode_e        mode,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt,
    output logic             period_evt,
    output logic             reach_zero
);

    ptb_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             run;

    assign run = (mode != MODE_HOLD);

    // Next direction and next count for the coming tick
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (mode)
            MODE_UP: begin
                state_d = ST_RISE;
                cnt_d   = (cnt_q >= prd) ? '0 : cnt_q + 1'b1;
            end
            MODE_DOWN: begin
                state_d = ST_FALL;
                cnt_d   = (cnt_q == '0) ? prd : cnt_q - 1'b1;
            end
            MODE_UPDN: begin
                unique case (state_q)
                    ST_FALL: begin
                        if (cnt_q == '0) begin
                            state_d = ST_RISE;
                            cnt_d   = (prd == '0) ? '0 : CNT_W'(1);
                        end else begin
                            cnt_d   = cnt_q - 1'b1;
                        end
                    end
                    default: begin
                        // ST_IDLE behaves as ST_RISE
                        if (cnt_q >= prd) begin
                            state_d = ST_FALL;
                            cnt_d   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                        end else begin
                            state_d = ST_RISE;
                            cnt_d   = cnt_q + 1'b1;
                        end
                    end
                endcase
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (tick) begin
            state_q <= state_d;
        end
    end

    // Outputs: count and event strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            zero_evt   <= 1'b0;
            period_evt <= 1'b0;
        end else if (tick) begin
            cnt_q      <= cnt_d;
            zero_evt   <= run && (cnt_d == '0);
            period_evt <= run && (cnt_d == prd);
        end else begin
            zero_evt   <= 1'b0;
            period_evt <= 1'b0;
        end
    end

    assign count      = cnt_q;
    assign reach_zero = tick && run && (cnt_d == '0);

endmodule

// File: rtl/ptb_regs.sv
module ptb_regs
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              reach_zero,
    output ptb_mode_e         mode,
    output logic [HS_W-1:0]   hs_idx,
    output logic [DV_W-1:0]   dv_idx,
    output logic              restart,
    output logic [CNT_W-1:0]  prd_act,
    output logic [CNT_W-1:0]  prd_shd,
    output logic [CNT_W-1:0]  ctrl_word
);

    logic imm_q;
    logic wr_ctrl;
    logic wr_prd;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign wr_prd  = wr_en && (wr_addr == A_PRD);
    assign restart = wr_ctrl;

    // Control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode   <= MODE_HOLD;
            imm_q  <= 1'b0;
            hs_idx <= '0;
            dv_idx <= '0;
        end else if (wr_ctrl) begin
            mode   <= ptb_mode_e'(wr_data[MODE_LSB +: MODE_W]);
            imm_q  <= wr_data[IMM_BIT];
            hs_idx <= wr_data[HS_LSB +: HS_W];
            dv_idx <= wr_data[DV_LSB +: DV_W];
        end
    end

    // Active period: immediate write, or shadow copy at zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_act <= '0;
        end else if (imm_q) begin
            if (wr_prd) begin
                prd_act <= wr_data;
            end
        end else if (reach_zero) begin
            prd_act <= prd_shd;
        end
    end

    // Shadow period: written only in shadow load mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_shd <= '0;
        end else if (wr_prd && !imm_q) begin
            prd_shd <= wr_data;
        end
    end

    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[MODE_LSB +: MODE_W]    = mode;
        ctrl_word[IMM_BIT]               = imm_q;
        ctrl_word[HS_LSB +: HS_W]        = hs_idx;
        ctrl_word[DV_LSB +: DV_W]        = dv_idx;
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  count_out,
    output logic              zero_evt,
    output logic              period_evt
);

    ptb_mode_e        mode_w;
    logic [HS_W-1:0]  hs_w;
    logic [DV_W-1:0]  dv_w;
    logic             restart_w;
    logic             tick_w;
    logic             reach_zero_w;
    logic [CNT_W-1:0] prd_act_w;
    logic [CNT_W-1:0] prd_shd_w;
    logic [CNT_W-1:0] ctrl_w;

    ptb_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .reach_zero (reach_zero_w),
        .mode       (mode_w),
        .hs_idx     (hs_w),
        .dv_idx     (dv_w),
        .restart    (restart_w),
        .prd_act    (prd_act_w),
        .prd_shd    (prd_shd_w),
        .ctrl_word  (ctrl_w)
    );

    ptb_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_w),
        .hs_idx  (hs_w),
        .dv_idx  (dv_w),
        .tick    (tick_w)
    );

    ptb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .mode       (mode_w),
        .prd        (prd_act_w),
        .count      (count_out),
        .zero_evt   (zero_evt),
        .period_evt (period_evt),
        .reach_zero (reach_zero_w)
    );

    // Read mux
    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = ctrl_w;
            A_PRD:   rd_data = prd_act_w;
            A_SHD:   rd_data = prd_shd_w;
            default: rd_data = count_out;
        endcase
    end

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             tick,
    input logic [CNT_W-1:0] prd_active,
    input logic [CNT_W-1:0] count_out,
    input logic             zero_evt,
    input logic             period_evt
);

    // R7: no strobes from a frozen counter
    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b11) |-> (!zero_evt && !period_evt));

    // R7: frozen count holds
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b11) |-> $stable(count_out));

    // R3: count moves only on a prescaler tick
    a_r3_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(count_out));

    // R8: zero strobe means a zero count
    a_r8_zero_value: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> (count_out == '0));

    // R8: period strobe matches the period used at the tick
    a_r8_period_value: assert property (@(posedge clk) disable iff (!rst_n)
        period_evt |-> (count_out == $past(prd_active)));

    // R8: strobes only follow a tick
    a_r8_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt || period_evt) |-> $past(tick));

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_w),
    .tick       (tick_w),
    .prd_active (prd_act_w),
    .count_out  (count_out),
    .zero_evt   (zero_evt),
    .period_evt (period_evt)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] count_out;
    logic        zero_evt;
    logic        period_evt;

    int n_checks = 0;
    int n_fail   = 0;

    pwm_timebase dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .count_out  (count_out),
        .zero_evt   (zero_evt),
        .period_evt (period_evt)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] prd;
    } vec_t;

    // Run configurations, all with immediate load (bit 3)
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'h0008, 16'd3},   // up, F=1
        '{16'h0009, 16'd4},   // down, F=1
        '{16'h000A, 16'd3},   // up-down, F=1
        '{16'h0488, 16'd2},   // up, F=2*2=4
        '{16'h018A, 16'd2},   // up-down, F=6
        '{16'h0809, 16'd1},   // down, F=4
        '{16'h0008, 16'd0}    // up, period 0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    function automatic int factor_of(input logic [15:0] c);
        int hs, dv;
        hs = int'(c[9:7]);
        dv = int'(c[12:10]);
        return ((hs == 0) ? 1 : 2 * hs) << dv;
    endfunction

    task automatic model_step(input logic [1:0] m, input int prd, inout int c, inout bit dn);
        case (m)
            2'b00: begin dn = 0; c = (c >= prd) ? 0 : c + 1; end
            2'b01: begin dn = 1; c = (c == 0) ? prd : c - 1; end
            2'b10: begin
                if (dn) begin
                    if (c == 0) begin dn = 0; c = (prd == 0) ? 0 : 1; end
                    else c = c - 1;
                end else begin
                    if (c >= prd) begin dn = 1; c = (c == 0) ? 0 : c - 1; end
                    else c = c + 1;
                end
            end
            default: ;
        endcase
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] hold_val;
        int f, mc, ln;
        bit md;
        string tag;

        // R1 / R11: reset state through the read port
        do_reset();
        check("R1 count", count_out, 16'd0);
        rd(2'd0, v); check("R1 ctrl", v, 16'h0003);
        rd(2'd1, v); check("R1 active period", v, 16'd0);
        rd(2'd2, v); check("R1 shadow period", v, 16'd0);
        check("R1 strobes", {zero_evt, period_evt}, 2'b00);

        // R2: field positions, unused bits read 0
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); check("R2 ctrl readback", v, 16'h1F8B);
        // R11: writes to addresses 2 and 3 are ignored
        wr(2'd2, 16'h1234);
        wr(2'd3, 16'h4321);
        rd(2'd2, v); check("R11 shadow untouched", v, 16'd0);
        rd(2'd3, v); check("R11 count untouched", v, 16'd0);
        rd(2'd1, v); check("R11 active untouched", v, 16'd0);

        // Table of run configurations
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(2'd0, 16'h000B);
            wr(2'd1, VECS[i].prd);
            wr(2'd0, VECS[i].ctrl);
            f  = factor_of(VECS[i].ctrl);
            mc = 0;
            md = 0;
            case (VECS[i].ctrl[1:0])
                2'b00:   tag = "R4";
                2'b01:   tag = "R5";
                default: tag = "R6";
            endcase
            for (int k = 0; k < 8; k++) begin
                repeat (f) @(posedge clk);
                #1;
                model_step(VECS[i].ctrl[1:0], int'(VECS[i].prd), mc, md);
                check($sformatf("%s vec%0d step%0d count", tag, i, k), count_out, mc);
                check($sformatf("R8 vec%0d step%0d zero", i, k), zero_evt, (mc == 0));
                check($sformatf("R8 vec%0d step%0d period", i, k), period_evt,
                      (mc == int'(VECS[i].prd)));
            end
            if (f > 1) begin
                @(posedge clk);
                #1;
                check($sformatf("R3 vec%0d between ticks", i), count_out, mc);
                check($sformatf("R8 vec%0d strobe width", i), {zero_evt, period_evt}, 2'b00);
            end
        end

        // R3: largest factor 14*128 = 1792
        do_reset();
        wr(2'd0, 16'h000B);
        wr(2'd1, 16'd5);
        wr(2'd0, 16'h1F88);
        repeat (1791) @(posedge clk);
        #1;
        check("R3 max factor before tick", count_out, 16'd0);
        @(posedge clk);
        #1;
        check("R3 max factor at tick", count_out, 16'd1);

        // R7: freeze holds the count and suppresses strobes
        do_reset();
        wr(2'd0, 16'h000B);
        wr(2'd1, 16'd5);
        wr(2'd0, 16'h0008);
        repeat (3) @(posedge clk);
        #1;
        hold_val = count_out;
        wr(2'd0, 16'h000B);
        for (int k = 0; k < 5; k++) begin
            check("R7 frozen count", count_out, hold_val);
            check("R7 frozen strobes", {zero_evt, period_evt}, 2'b00);
            @(posedge clk);
            #1;
        end

        // R9: immediate load leaves the shadow alone
        wr(2'd1, 16'd7);
        rd(2'd1, v); check("R9 active immediate", v, 16'd7);
        rd(2'd2, v); check("R9 shadow unchanged", v, 16'd0);

        // R10: shadow load and write on the wrap edge
        do_reset();
        wr(2'd0, 16'h000B);
        wr(2'd1, 16'd3);
        wr(2'd0, 16'h0003);
        wr(2'd1, 16'd5);
        rd(2'd1, v); check("R10 active held", v, 16'd3);
        rd(2'd2, v); check("R10 shadow written", v, 16'd5);
        wr(2'd0, 16'h0000);
        ln = 0;
        while (count_out != 16'd3 && ln < 20) begin
            @(posedge clk);
            #1;
            ln++;
        end
        wr(2'd1, 16'd9);
        check("R10 wrap count", count_out, 16'd0);
        rd(2'd1, v); check("R10 active takes old shadow", v, 16'd5);
        rd(2'd2, v); check("R10 shadow takes new write", v, 16'd9);
        repeat (6) @(posedge clk);
        #1;
        check("R10 second wrap count", count_out, 16'd0);
        check("R10 second wrap zero strobe", zero_evt, 1'b1);
        rd(2'd1, v); check("R10 active takes new shadow", v, 16'd9);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule